// File: doc/BRIEF.md
# Transmit Descriptor Ownership Processor

This block walks a chain of transmit descriptors that host software builds in shared memory. Each descriptor is four 32-bit words: an ownership word, a control word, a buffer address and a pointer to the next descriptor. The block reads the ownership word first. If the device does not own the descriptor, the block stops and waits on that same descriptor. If the device owns it, the block reads the other three words and hands the buffer to a transmit data mover. When the mover is finished, the block writes the ownership word back cleared. It then follows the next pointer.

Frames can span several buffers. The block marks them with first-segment and last-segment flags and keeps a small frame tracker. When a frame closes with an interrupt request, the block raises a one-cycle transmit interrupt and a status level that software can clear. A descriptor that breaks the first/last framing sets a sticky error flag. If the break leaves a partial frame open, the block tells the mover to discard that frame.

Top module: `tx_desc_owner`

## Requirements
- R1: After reset the first memory access is a read of byte address `RING_BASE`. `irq_pulse`, `irq_status`, `frame_err`, `mv_valid` and `mv_drop` are all low.
- R2: Bit 31 of word 0 (offset 0) is the ownership flag. When it reads 0, the block makes no further memory access until `poll_req` is pulsed, and then it re-reads word 0 of the same descriptor.
- R3: When bit 31 of word 0 reads 1, the block reads three more words. Word 1 (offset 4) holds interrupt request (bit 31), first segment (bit 30), last segment (bit 29) and byte count (bits LEN_W-1:0). Word 2 (offset 8) is the buffer address. Word 3 (offset 12) is the next descriptor address, and its two low bits are ignored so every descriptor access is word aligned.
- R4: An accepted descriptor with a nonzero count drives `mv_valid` with its buffer address, count, first and last flags. These stay stable until `mv_done`.
- R5: An accepted descriptor with a zero byte count makes no transfer, but its ownership is still returned.
- R6: Every descriptor whose ownership word read 1 gets word 0 written to all zeros. That write is acknowledged before word 0 of any following descriptor is read.
- R7: An accepted descriptor that carries both the last-segment flag and the interrupt request produces `irq_pulse` high for exactly one cycle, in the cycle after its write-back is acknowledged. An interrupt request without the last-segment flag has no effect.
- R8: `irq_status` is set together with `irq_pulse` and holds until `irq_clr` is high. If both happen in the same cycle, the set wins.
- R9: A descriptor without the first-segment flag that arrives while no frame is open sets `frame_err`. It is not transferred, but its ownership is returned.
- R10: A descriptor with the first-segment flag that arrives while a frame is open does three things: it sets `frame_err`, pulses `mv_drop` for one cycle, and starts a new frame itself.
- R11: `frame_err` stays set until reset.
- R12: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`. Read data is taken in the cycle of `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_req | input | 1 | Poll demand: restart from the stopped descriptor |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | 32 | Read data |
| mv_valid | output | 1 | Buffer offered to the data mover |
| mv_addr | output | AW | Buffer address |
| mv_len | output | LEN_W | Buffer byte count |
| mv_first | output | 1 | Buffer opens a frame |
| mv_last | output | 1 | Buffer closes a frame |
| mv_done | input | 1 | Mover finished the buffer |
| mv_drop | output | 1 | Discard the partial frame in the mover |
| irq_pulse | output | 1 | One-cycle transmit interrupt |
| irq_status | output | 1 | Interrupt level status |
| irq_clr | input | 1 | Clears the interrupt status |
| frame_err | output | 1 | Sticky framing error |

## Verification
The hardest condition to reach is a framing fault in the middle of a frame. A new first segment must arrive while an earlier frame is still open, and any memory or mover stall can move it in time. Directed rounds place such a chain in the ring before the poll demand. Random rounds then mix all four first/last combinations with random handshake delays, zero counts and junk in the low bits of next pointers. The bench keeps its own open-frame state across rounds so that every expected drop, transfer and interrupt can be predicted.

// File: rtl/tdo_pkg.sv
package tdo_pkg;

    typedef enum logic [2:0] {
        ST_OWN  = 3'd0,
        ST_CTL  = 3'd1,
        ST_BUF  = 3'd2,
        ST_NXT  = 3'd3,
        ST_XFER = 3'd4,
        ST_WB   = 3'd5,
        ST_STOP = 3'd6
    } tdo_state_e;

    localparam int OWN_BIT = 31;
    localparam int IRQ_BIT = 31;
    localparam int FS_BIT  = 30;
    localparam int LS_BIT  = 29;

    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/tdo_frame_track.sv
module tdo_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic seg_first,
    input  logic seg_last,
    output logic accept,
    output logic drop,
    output logic err
);

    typedef struct packed {
        logic open;
        logic err;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d  = trk_q;
        accept = seg_first | trk_q.open;
        drop   = eval & seg_first & trk_q.open;
        if (eval) begin
            if (accept) begin
                trk_d.open = ~seg_last;
            end
            if ((seg_first & trk_q.open) | (~seg_first & ~trk_q.open)) begin
                trk_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign err = trk_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R11
    AST_DROP_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err); // R10

endmodule

// File: rtl/tdo_irq.sv
module tdo_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    output logic pulse,
    output logic status
);

    typedef struct packed {
        logic pulse;
        logic status;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d.pulse  = fire;
        irq_d.status = fire | (irq_q.status & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign pulse  = irq_q.pulse;
    assign status = irq_q.status;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R7
    AST_STATUS_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> status); // R8

endmodule

// File: rtl/tx_desc_owner.sv
module tx_desc_owner #(
    parameter int AW = 32,
    parameter int LEN_W = 11,
    parameter logic [AW-1:0] RING_BASE = 'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_req,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             mv_valid,
    output logic [AW-1:0]    mv_addr,
    output logic [LEN_W-1:0] mv_len,
    output logic             mv_first,
    output logic             mv_last,
    input  logic             mv_done,
    output logic             mv_drop,
    output logic             irq_pulse,
    output logic             irq_status,
    input  logic             irq_clr,
    output logic             frame_err
);
    import tdo_pkg::*;

    localparam logic [AW-1:0] OFF_CTL = AW'(WORD_BYTES);
    localparam logic [AW-1:0] OFF_BUF = AW'(2 * WORD_BYTES);
    localparam logic [AW-1:0] OFF_NXT = AW'(3 * WORD_BYTES);

    typedef struct packed {
        tdo_state_e       st;
        logic [AW-1:0]    cur;
        logic [AW-1:0]    nxt;
        logic [AW-1:0]    buf_a;
        logic [LEN_W-1:0] len;
        logic             irq_req;
        logic             seg_f;
        logic             seg_l;
        logic             fire;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic eval, accept, wb_done;

    tdo_frame_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval      (eval),
        .seg_first (ctx_q.seg_f),
        .seg_last  (ctx_q.seg_l),
        .accept    (accept),
        .drop      (mv_drop),
        .err       (frame_err)
    );

    tdo_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (wb_done & ctx_q.fire),
        .clr    (irq_clr),
        .pulse  (irq_pulse),
        .status (irq_status)
    );

    always_comb begin
        ctx_d     = ctx_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ctx_q.cur;
        mem_wdata = '0;
        mv_valid  = 1'b0;
        eval      = 1'b0;
        wb_done   = 1'b0;
        unique case (ctx_q.st)
            ST_OWN: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    ctx_d.st = mem_rdata[OWN_BIT] ? ST_CTL : ST_STOP;
                end
            end
            ST_CTL: begin
                mem_req  = 1'b1;
                mem_addr = ctx_q.cur + OFF_CTL;
                if (mem_ack) begin
                    ctx_d.irq_req = mem_rdata[IRQ_BIT];
                    ctx_d.seg_f   = mem_rdata[FS_BIT];
                    ctx_d.seg_l   = mem_rdata[LS_BIT];
                    ctx_d.len     = mem_rdata[LEN_W-1:0];
                    ctx_d.st      = ST_BUF;
                end
            end
            ST_BUF: begin
                mem_req  = 1'b1;
                mem_addr = ctx_q.cur + OFF_BUF;
                if (mem_ack) begin
                    ctx_d.buf_a = mem_rdata[AW-1:0];
                    ctx_d.st    = ST_NXT;
                end
            end
            ST_NXT: begin
                mem_req  = 1'b1;
                mem_addr = ctx_q.cur + OFF_NXT;
                if (mem_ack) begin
                    eval       = 1'b1;
                    ctx_d.nxt  = {mem_rdata[AW-1:2], 2'b00};
                    ctx_d.fire = accept & ctx_q.seg_l & ctx_q.irq_req;
                    ctx_d.st   = (accept && ctx_q.len != '0) ? ST_XFER : ST_WB;
                end
            end
            ST_XFER: begin
                mv_valid = 1'b1;
                if (mv_done) begin
                    ctx_d.st = ST_WB;
                end
            end
            ST_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    wb_done   = 1'b1;
                    ctx_d.cur = ctx_q.nxt;
                    ctx_d.st  = ST_OWN;
                end
            end
            ST_STOP: begin
                if (poll_req) begin
                    ctx_d.st = ST_OWN;
                end
            end
            default: ctx_d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q     <= '0;
            ctx_q.st  <= ST_OWN;
            ctx_q.cur <= {RING_BASE[AW-1:2], 2'b00};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mv_addr  = ctx_q.buf_a;
    assign mv_len   = ctx_q.len;
    assign mv_first = ctx_q.seg_f;
    assign mv_last  = ctx_q.seg_l;

    // Checker state: a descriptor is held between its control read and its write-back.
    logic pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mem_req && mem_ack && mem_we) begin
            pend_q <= 1'b0;
        end else if (mem_req && mem_ack && (mem_addr == ctx_q.cur + OFF_CTL)) begin
            pend_q <= 1'b1;
        end
    end

    AST_WB_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_addr == ctx_q.cur && pend_q) |-> 1'b0); // R6
    AST_WB_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == 32'd0)); // R6
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12
    AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_done) |=> (mv_valid && $stable(mv_addr) && $stable(mv_len) && $stable(mv_first) && $stable(mv_last))); // R4
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_NO_EMPTY_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> (mv_len != '0)); // R5

endmodule

// File: tb/sim_tx_desc_owner.sv
module sim_tx_desc_owner;
    localparam int AW = 32;
    localparam int LEN_W = 11;
    localparam logic [31:0] BASE = 32'h0000_0100;
    localparam int NSLOT = 16;

    logic clk, rst_n, poll_req, irq_clr;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic mv_valid, mv_first, mv_last, mv_done, mv_drop;
    logic [AW-1:0] mv_addr;
    logic [LEN_W-1:0] mv_len;
    logic irq_pulse, irq_status, frame_err;

    tx_desc_owner #(.AW(AW), .LEN_W(LEN_W), .RING_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .poll_req(poll_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_valid(mv_valid), .mv_addr(mv_addr), .mv_len(mv_len),
        .mv_first(mv_first), .mv_last(mv_last), .mv_done(mv_done),
        .mv_drop(mv_drop), .irq_pulse(irq_pulse), .irq_status(irq_status),
        .irq_clr(irq_clr), .frame_err(frame_err)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    logic [31:0] mem [64];
    int n_rd0 = 0, n_wr = 0, n_acc = 0, ord_err = 0, hold_err = 0, oob_err = 0;
    int n_tx = 0, n_irq = 0, n_drop = 0;
    logic [31:0] last_rd0, first_addr;
    logic first_we, seen_first = 1'b0, pend = 1'b0, prev_wait = 1'b0;
    logic [31:0] prev_addr;
    logic [31:0] tx_addr [64];
    int tx_len [64];
    logic tx_f [64], tx_l [64];
    int ack_pct = 70, done_pct = 60;

    // memory responder
    initial begin
        mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                if (!seen_first) begin
                    seen_first = 1'b1; first_addr = mem_addr; first_we = mem_we;
                end
                if (prev_wait && mem_addr !== prev_addr) hold_err++;
                if ($urandom_range(99) < ack_pct) begin
                    int idx;
                    idx = int'((mem_addr - BASE) >> 2);
                    n_acc++;
                    if (idx < 0 || idx >= 64) begin
                        oob_err++;
                    end else if (mem_we) begin
                        mem[idx] = mem_wdata;
                        n_wr++;
                        pend = 1'b0;
                    end else begin
                        mem_rdata = mem[idx];
                        if (idx % 4 == 0) begin
                            n_rd0++; last_rd0 = mem_addr;
                            if (pend) ord_err++;
                        end
                        if (idx % 4 == 1) pend = 1'b1;
                    end
                    mem_ack = 1'b1;
                    prev_wait = 1'b0;
                end else begin
                    prev_wait = 1'b1; prev_addr = mem_addr;
                end
            end else begin
                prev_wait = 1'b0;
            end
        end
    end

    // mover responder and event monitor
    initial begin
        mv_done = 1'b0;
        forever begin
            @(negedge clk);
            mv_done = 1'b0;
            if (rst_n) begin
                if (irq_pulse) n_irq++;
                if (mv_drop) n_drop++;
                if (mv_valid && $urandom_range(99) < done_pct) begin
                    if (n_tx < 64) begin
                        tx_addr[n_tx] = mv_addr; tx_len[n_tx] = int'(mv_len);
                        tx_f[n_tx] = mv_first; tx_l[n_tx] = mv_last;
                    end
                    n_tx++;
                    mv_done = 1'b1;
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // descriptor plan and reference model
    logic d_fs [NSLOT], d_ls [NSLOT], d_ic [NSLOT];
    int d_len [NSLOT];
    int cur_slot = 0;
    logic exp_open = 1'b0, exp_err = 1'b0;

    task automatic pulse_poll();
        @(negedge clk); poll_req = 1'b1;
        @(negedge clk); poll_req = 1'b0;
    endtask

    task automatic run_round(input int k);
        logic [31:0] e_addr [64];
        int e_len [64];
        logic e_f [64], e_l [64];
        int e_n = 0, e_irq = 0, e_drop = 0, t, bad, na;
        for (int i = 0; i < k; i++) begin
            int s, b;
            logic snd;
            logic [31:0] bufa;
            s = (cur_slot + i) % NSLOT; b = 4 * s;
            bufa = 32'h8000_0000 | ($urandom & 32'h00ff_fffc);
            mem[b]   = 32'h8000_0000 | ($urandom & 32'h7fff_ffff);
            mem[b+1] = {d_ic[i], d_fs[i], d_ls[i], 18'($urandom), 11'(d_len[i])};
            mem[b+2] = bufa;
            mem[b+3] = BASE + 32'(16 * ((s + 1) % NSLOT)) + 32'($urandom_range(3));
            snd = d_fs[i] | exp_open;
            if (d_fs[i] && exp_open) e_drop++;
            if ((d_fs[i] && exp_open) || (!d_fs[i] && !exp_open)) exp_err = 1'b1;
            if (snd) exp_open = ~d_ls[i];
            if (snd && d_len[i] != 0) begin
                e_addr[e_n] = bufa; e_len[e_n] = d_len[i];
                e_f[e_n] = d_fs[i]; e_l[e_n] = d_ls[i]; e_n++;
            end
            if (snd && d_ls[i] && d_ic[i]) e_irq++;
        end
        t = (cur_slot + k) % NSLOT;
        mem[4*t] = $urandom & 32'h7fff_ffff;
        n_tx = 0; n_irq = 0; n_drop = 0; n_wr = 0;
        pulse_poll();
        while (n_wr < k) @(negedge clk);
        repeat (40) @(negedge clk);
        check(n_tx == e_n, "R4/R5 transfer count", n_tx, e_n);
        for (int i = 0; i < e_n && i < n_tx; i++) begin
            check(tx_addr[i] == e_addr[i] && tx_len[i] == e_len[i] &&
                  tx_f[i] == e_f[i] && tx_l[i] == e_l[i],
                  "R4 R3 transfer fields (addr)", tx_addr[i], e_addr[i]);
        end
        check(n_irq == e_irq, "R7 interrupt pulses", n_irq, e_irq);
        check(n_drop == e_drop, "R10 drop pulses", n_drop, e_drop);
        check(frame_err == exp_err, "R9 R11 frame_err", frame_err, exp_err);
        bad = 0;
        for (int i = 0; i < k; i++) if (mem[4 * ((cur_slot + i) % NSLOT)] != 32'd0) bad++;
        check(bad == 0, "R6 ownership words returned", bad, 0);
        check(last_rd0 == BASE + 32'(16 * t), "R2 stops on unowned descriptor", last_rd0, BASE + 32'(16 * t));
        na = n_acc;
        repeat (10) @(negedge clk);
        check(n_acc == na, "R2 no access while stopped", n_acc, na);
        cur_slot = t;
    endtask

    task automatic set_desc(input int i, input logic ic, input logic fs, input logic ls, input int len);
        d_ic[i] = ic; d_fs[i] = fs; d_ls[i] = ls; d_len[i] = len;
    endtask

    initial begin
        void'($urandom(32'h1d5c_0a7e));
        rst_n = 1'b0; poll_req = 1'b0; irq_clr = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_pulse == 0 && irq_status == 0 && frame_err == 0 && mv_valid == 0 && mv_drop == 0,
              "R1 outputs after reset", {irq_pulse, irq_status, frame_err, mv_valid}, 0);
        repeat (20) @(negedge clk);
        check(seen_first && first_addr == BASE && first_we == 0, "R1 first access address", first_addr, BASE);
        check(n_rd0 == 1, "R2 stopped after unowned word", n_rd0, 1);
        pulse_poll();
        repeat (20) @(negedge clk);
        check(n_rd0 == 2 && last_rd0 == BASE, "R2 poll re-reads same descriptor", n_rd0, 2);

        // single-buffer frame with interrupt
        set_desc(0, 1, 1, 1, 64);
        run_round(1);
        check(irq_status == 1, "R8 status set", irq_status, 1);
        // three-buffer frame, request only on first: no interrupt
        set_desc(0, 1, 1, 0, 100); set_desc(1, 0, 0, 0, 7); set_desc(2, 0, 0, 1, 1);
        run_round(3);
        check(irq_status == 1, "R8 status holds without clear", irq_status, 1);
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        @(negedge clk);
        check(irq_status == 0, "R8 status cleared", irq_status, 0);
        // zero-length buffer closing a frame with request
        set_desc(0, 1, 1, 1, 0);
        run_round(1);
        check(irq_status == 1, "R5 R7 zero-length still completes", irq_status, 1);
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        // first segment while a frame is open
        set_desc(0, 0, 1, 0, 32); set_desc(1, 1, 1, 1, 16);
        run_round(2);
        // orphan last segment
        set_desc(0, 1, 0, 1, 8);
        run_round(1);

        // random rounds with random handshake delays
        for (int r = 0; r < 25; r++) begin
            int k;
            k = $urandom_range(6, 1);
            ack_pct = $urandom_range(95, 30);
            done_pct = $urandom_range(95, 30);
            for (int i = 0; i < k; i++) begin
                set_desc(i, 1'($urandom), 1'($urandom), 1'($urandom),
                         ($urandom_range(9) == 0) ? 0 : int'($urandom_range(2047, 1)));
            end
            run_round(k);
        end

        check(frame_err == 1, "R11 error still set", frame_err, 1);
        check(ord_err == 0, "R6 write-back before next fetch", ord_err, 0);
        check(hold_err == 0, "R12 request held stable", hold_err, 0);
        check(oob_err == 0, "R3 aligned descriptor addresses", oob_err, 0);
        summary();
        $finish;
    end

endmodule